// File: doc/BRIEF.md
# ATA Transfer Command Sequencer

This block sits behind a register-style host command port and runs one sector-based read, write or verify command at a time. The host presents an opcode, a sector count and a starting logical block address together with a single-cycle strobe. The sequencer works out how many sectors the command really asks for and checks the whole span against the current address ceiling. It then either fails the command at once or opens a data phase. During that phase an external data mover reports each finished sector with a one-cycle pulse. The sequencer advances the current address, keeps track of what remains and raises an interrupt pulse at the points the command family calls for.

The block also keeps two pieces of host-set state. The first is the block size used by the multiple-sector commands. The second is a lowerable address ceiling, which can be set back to the factory native maximum at any time. Read, write and verify commands, multiple-sector transfers, the block-size command and the native-maximum query and set commands are decoded. Every other opcode completes with an abort.

Top module: `ata_xfer_seq`

## Requirements
- R1: For the 28-bit read and write opcodes (20h, 21h, 30h, C4h, C5h), and for read verify 40h/41h, only the low 8 bits of the count are used, and a value of 0 stands for 256 sectors.
- R2: For the extended opcodes (24h, 34h, 29h, 39h, 42h) the full 16-bit count is used, and a value of 0 stands for 65536 sectors.
- R3: A read, write or verify whose last sector (start + count − 1) lies above `max_lba` sets `err_idnf`, never raises DRQ, moves no sector and gives one interrupt. `cur_lba` then holds the start address.
- R4: Set-max (F9h, 37h) copies `cmd_lba` into `max_lba` when it is no greater than NATIVE_MAX, and aborts otherwise. Later range checks use the new value. `max_lba` equals NATIVE_MAX after reset.
- R5: Read-native-max (F8h, 27h) puts NATIVE_MAX on `cur_lba` whatever `max_lba` currently holds.
- R6: Multiple-sector opcodes (C4h, C5h, 29h, 39h) interrupt once per full block of sectors, and once more on the last sector when that sector closes a partial block. After reset the block size is 16.
- R7: Set-multiple (C6h) takes its block size from `cmd_count`. A size that is a power of two from 1 to MAX_BLK is stored. Any other value, including 0, aborts and keeps the old size.
- R8: Read verify (40h, 41h, 42h) keeps BSY high, never raises DRQ, advances `cur_lba` by one sector per clock and gives one interrupt at the end.
- R9: Opcode 00h and every undecoded opcode complete with `err_abort` and one interrupt.
- R10: A strobe in idle raises BSY on the next clock. Data-in and data-out commands then drop BSY and raise DRQ one clock later. `cur_lba` goes up by one per `sector_done`. `err_idnf` and `err_abort` keep their value until the next accepted strobe, which clears them.
- R11: Single-sector read and write commands interrupt once per sector. `intrq` is a pulse that is never high while BSY is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe, taken only when idle |
| cmd_op | input | 8 | Command opcode |
| cmd_count | input | 16 | Sector count field, or block size for set-multiple |
| cmd_lba | input | LBA_W | Starting address, or new ceiling for set-max |
| sector_done | input | 1 | Pulse from the data mover per sector moved |
| bsy | output | 1 | Busy |
| drq | output | 1 | Data request, high for the data phase |
| intrq | output | 1 | One-cycle interrupt pulse |
| err_idnf | output | 1 | Address-not-found error of the last command |
| err_abort | output | 1 | Command-aborted flag of the last command |
| cur_lba | output | LBA_W | Current sector address, or native maximum after a query |
| max_lba | output | LBA_W | Current host-visible address ceiling |

## Verification
A wrong resolved count or a wrong block size shows up at the ports as a wrong number of interrupt pulses. It also shows up as a final `cur_lba` that is off by whole sectors, and this is visible as soon as the command ends. A faulty range check or ceiling register lets DRQ rise on a command that should fail, or raises `err_idnf` on a command that should pass. This is visible two clocks after the strobe, before any sector moves. Because stored block size and ceiling carry over between commands, the vectors are ordered so that a corrupted update breaks the counts of the next command.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;

   typedef enum logic [2:0] {
      K_READ, K_WRITE, K_VERIFY, K_SETMULT, K_SETMAX, K_NATIVE, K_ABORT
   } cmd_kind_e;

   typedef enum logic [1:0] {
      S_IDLE, S_CHECK, S_XFER, S_VERIFY
   } seq_state_e;

   localparam logic [7:0] OP_RD       = 8'h20;
   localparam logic [7:0] OP_RD_NR    = 8'h21;
   localparam logic [7:0] OP_RD_X     = 8'h24;
   localparam logic [7:0] OP_NMAX_X   = 8'h27;
   localparam logic [7:0] OP_RDM_X    = 8'h29;
   localparam logic [7:0] OP_WR       = 8'h30;
   localparam logic [7:0] OP_WR_X     = 8'h34;
   localparam logic [7:0] OP_SMAX_X   = 8'h37;
   localparam logic [7:0] OP_WRM_X    = 8'h39;
   localparam logic [7:0] OP_VFY      = 8'h40;
   localparam logic [7:0] OP_VFY_NR   = 8'h41;
   localparam logic [7:0] OP_VFY_X    = 8'h42;
   localparam logic [7:0] OP_RDM      = 8'hC4;
   localparam logic [7:0] OP_WRM      = 8'hC5;
   localparam logic [7:0] OP_SETM     = 8'hC6;
   localparam logic [7:0] OP_NMAX     = 8'hF8;
   localparam logic [7:0] OP_SMAX     = 8'hF9;

endpackage

// File: rtl/ata_cmd_decode.sv
module ata_cmd_decode
   import ata_seq_pkg::*;
#(
   parameter bit EXT_EN = 1'b1
) (
   input  logic [7:0] op,
   output cmd_kind_e  kind,
   output logic       wide_cnt,
   output logic       blk_mode
);

   logic ext_ok;

   generate
      if (EXT_EN) begin : ext_g
         assign ext_ok = 1'b1;
      end else begin : noext_g
         assign ext_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      kind     = K_ABORT;
      wide_cnt = 1'b0;
      blk_mode = 1'b0;
      case (op)
         OP_RD, OP_RD_NR:        kind = K_READ;
         OP_WR:                  kind = K_WRITE;
         OP_VFY, OP_VFY_NR:      kind = K_VERIFY;
         OP_RDM: begin           kind = K_READ;  blk_mode = 1'b1; end
         OP_WRM: begin           kind = K_WRITE; blk_mode = 1'b1; end
         OP_SETM:                kind = K_SETMULT;
         OP_SMAX:                kind = K_SETMAX;
         OP_NMAX:                kind = K_NATIVE;
         OP_RD_X: begin
            kind = ext_ok ? K_READ : K_ABORT;   wide_cnt = 1'b1;
         end
         OP_WR_X: begin
            kind = ext_ok ? K_WRITE : K_ABORT;  wide_cnt = 1'b1;
         end
         OP_VFY_X: begin
            kind = ext_ok ? K_VERIFY : K_ABORT; wide_cnt = 1'b1;
         end
         OP_RDM_X: begin
            kind = ext_ok ? K_READ : K_ABORT;   wide_cnt = 1'b1; blk_mode = 1'b1;
         end
         OP_WRM_X: begin
            kind = ext_ok ? K_WRITE : K_ABORT;  wide_cnt = 1'b1; blk_mode = 1'b1;
         end
         OP_SMAX_X:              kind = ext_ok ? K_SETMAX : K_ABORT;
         OP_NMAX_X:              kind = ext_ok ? K_NATIVE : K_ABORT;
         default:                kind = K_ABORT;
      endcase
   end

endmodule

// File: rtl/ata_range_chk.sv
module ata_range_chk #(
   parameter int LBA_W = 32,
   parameter int CNT_W = 17
) (
   input  logic [LBA_W-1:0] start,
   input  logic [CNT_W-1:0] count,
   input  logic [LBA_W-1:0] limit,
   output logic             in_range
);

   localparam int SUM_W = LBA_W + 1;

   logic [SUM_W-1:0] last_sec;

   generate
      if (CNT_W > LBA_W) begin : bad_cnt_g
         $error("sector count wider than address");
      end
   endgenerate

   always_comb begin
      last_sec = {1'b0, start} + SUM_W'(count) - SUM_W'(1);
      in_range = (count != '0) && (last_sec <= {1'b0, limit});
   end

endmodule

// File: rtl/ata_blk_size.sv
module ata_blk_size #(
   parameter int MAX_BLK = 128,
   parameter int DEF_BLK = 16,
   parameter int REQ_W   = 16,
   parameter int BLK_W   = $clog2(MAX_BLK) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REQ_W-1:0] req,
   output logic [BLK_W-1:0] size,
   output logic             req_ok
);

   int unsigned ones_n;

   generate
      if (DEF_BLK > MAX_BLK || DEF_BLK < 1) begin : bad_def_g
         $error("default block size out of range");
      end
      if ((DEF_BLK & (DEF_BLK - 1)) != 0) begin : bad_pow_g
         $error("default block size not a power of two");
      end
   endgenerate

   always_comb begin
      ones_n = 0;
      for (int i = 0; i < REQ_W; i++) begin
         ones_n = ones_n + 32'(req[i]);
      end
      req_ok = (ones_n == 1) && (req <= REQ_W'(MAX_BLK));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size <= BLK_W'(DEF_BLK);
      end else if (wr_en && req_ok) begin
         size <= BLK_W'(req);
      end
   end

   // R7
   size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(size) && (size <= BLK_W'(MAX_BLK)));

endmodule

// File: rtl/ata_xfer_seq.sv
module ata_xfer_seq
   import ata_seq_pkg::*;
#(
   parameter int               LBA_W      = 32,
   parameter logic [LBA_W-1:0] NATIVE_MAX = 32'h000F_FFFF,
   parameter int               MAX_BLK    = 128,
   parameter int               DEF_BLK    = 16,
   parameter bit               EXT_EN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [7:0]       cmd_op,
   input  logic [15:0]      cmd_count,
   input  logic [LBA_W-1:0] cmd_lba,
   input  logic             sector_done,
   output logic             bsy,
   output logic             drq,
   output logic             intrq,
   output logic             err_idnf,
   output logic             err_abort,
   output logic [LBA_W-1:0] cur_lba,
   output logic [LBA_W-1:0] max_lba
);

   localparam int CNT_W = 17;
   localparam int BLK_W = $clog2(MAX_BLK) + 1;

   generate
      if (LBA_W < 28) begin : bad_lba_g
         $error("address width below 28 bits");
      end
      if (MAX_BLK > 32768) begin : bad_max_g
         $error("block size limit too large");
      end
   endgenerate

   seq_state_e       state;
   cmd_kind_e        dec_kind, kind_q;
   logic             dec_wide, dec_blk;
   logic             wide_q, blk_q;
   logic [15:0]      cnt_q;
   logic [CNT_W-1:0] cnt_res, remain;
   logic [BLK_W-1:0] blk_cnt, blk_size;
   logic             in_range, setm_ok, setm_wr;
   logic             last_sec, blk_end;

   ata_cmd_decode #(.EXT_EN(EXT_EN)) dec_i (
      .op       (cmd_op),
      .kind     (dec_kind),
      .wide_cnt (dec_wide),
      .blk_mode (dec_blk)
   );

   always_comb begin
      if (wide_q) begin
         cnt_res = (cnt_q == 16'd0) ? CNT_W'(65536) : CNT_W'(cnt_q);
      end else begin
         cnt_res = (cnt_q[7:0] == 8'd0) ? CNT_W'(256) : CNT_W'(cnt_q[7:0]);
      end
   end

   ata_range_chk #(.LBA_W(LBA_W), .CNT_W(CNT_W)) rng_i (
      .start    (cur_lba),
      .count    (cnt_res),
      .limit    (max_lba),
      .in_range (in_range)
   );

   assign setm_wr = (state == S_CHECK) && (kind_q == K_SETMULT);

   ata_blk_size #(.MAX_BLK(MAX_BLK), .DEF_BLK(DEF_BLK), .REQ_W(16), .BLK_W(BLK_W)) blk_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (setm_wr),
      .req    (cnt_q),
      .size   (blk_size),
      .req_ok (setm_ok)
   );

   assign last_sec = (remain == CNT_W'(1));
   assign blk_end  = !blk_q || ((blk_cnt + BLK_W'(1)) == blk_size);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         kind_q    <= K_ABORT;
         wide_q    <= 1'b0;
         blk_q     <= 1'b0;
         cnt_q     <= '0;
         remain    <= '0;
         blk_cnt   <= '0;
         bsy       <= 1'b0;
         drq       <= 1'b0;
         intrq     <= 1'b0;
         err_idnf  <= 1'b0;
         err_abort <= 1'b0;
         cur_lba   <= '0;
         max_lba   <= NATIVE_MAX;
      end else begin
         intrq <= 1'b0;
         case (state)
            S_IDLE: begin
               if (cmd_valid) begin
                  kind_q    <= dec_kind;
                  wide_q    <= dec_wide;
                  blk_q     <= dec_blk;
                  cnt_q     <= cmd_count;
                  cur_lba   <= cmd_lba;
                  bsy       <= 1'b1;
                  err_idnf  <= 1'b0;
                  err_abort <= 1'b0;
                  state     <= S_CHECK;
               end
            end
            S_CHECK: begin
               case (kind_q)
                  K_READ, K_WRITE, K_VERIFY: begin
                     if (!in_range) begin
                        err_idnf <= 1'b1;
                        intrq    <= 1'b1;
                        bsy      <= 1'b0;
                        state    <= S_IDLE;
                     end else begin
                        remain  <= cnt_res;
                        blk_cnt <= '0;
                        if (kind_q == K_VERIFY) begin
                           state <= S_VERIFY;
                        end else begin
                           bsy   <= 1'b0;
                           drq   <= 1'b1;
                           state <= S_XFER;
                        end
                     end
                  end
                  K_SETMULT: begin
                     err_abort <= !setm_ok;
                     intrq     <= 1'b1;
                     bsy       <= 1'b0;
                     state     <= S_IDLE;
                  end
                  K_SETMAX: begin
                     if (cur_lba <= NATIVE_MAX) begin
                        max_lba <= cur_lba;
                     end else begin
                        err_abort <= 1'b1;
                     end
                     intrq <= 1'b1;
                     bsy   <= 1'b0;
                     state <= S_IDLE;
                  end
                  K_NATIVE: begin
                     cur_lba <= NATIVE_MAX;
                     intrq   <= 1'b1;
                     bsy     <= 1'b0;
                     state   <= S_IDLE;
                  end
                  default: begin
                     err_abort <= 1'b1;
                     intrq     <= 1'b1;
                     bsy       <= 1'b0;
                     state     <= S_IDLE;
                  end
               endcase
            end
            S_XFER: begin
               if (sector_done) begin
                  cur_lba <= cur_lba + LBA_W'(1);
                  remain  <= remain - CNT_W'(1);
                  if (last_sec) begin
                     drq   <= 1'b0;
                     intrq <= 1'b1;
                     state <= S_IDLE;
                  end else if (blk_end) begin
                     intrq   <= 1'b1;
                     blk_cnt <= '0;
                  end else begin
                     blk_cnt <= blk_cnt + BLK_W'(1);
                  end
               end
            end
            S_VERIFY: begin
               cur_lba <= cur_lba + LBA_W'(1);
               remain  <= remain - CNT_W'(1);
               if (last_sec) begin
                  intrq <= 1'b1;
                  bsy   <= 1'b0;
                  state <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R10
   drq_bsy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bsy && drq));

   // R10
   bsy_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && state == S_IDLE) |=> bsy);

   // R11
   intrq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      intrq |-> !bsy);

   // R8
   verify_nodrq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == K_VERIFY) |-> !drq);

   // R3
   drq_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drq) |-> (cur_lba <= max_lba));

   // R4
   max_le_native_chk: assert property (@(posedge clk) disable iff (!rst_n)
      max_lba <= NATIVE_MAX);

   // R9
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_idnf && err_abort));

endmodule

// File: tb/ata_xfer_seq_tb.sv
module ata_xfer_seq_tb_top;

   localparam int          CLK_P  = 10;
   localparam logic [31:0] NATIVE = 32'h000F_FFFF;

   typedef struct packed {
      logic [7:0]  op;
      logic [15:0] cnt;
      logic [31:0] lba;
      logic [31:0] sect;
      logic [31:0] irqs;
      logic        idnf;
      logic        abrt;
      logic [31:0] cur;
      logic [31:0] mx;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      '{8'h20, 16'd3,   32'd100,     32'd3,   32'd3,   1'b0, 1'b0, 32'd103,     NATIVE,      8'd1},  // R1
      '{8'h30, 16'd1,   32'd0,       32'd1,   32'd1,   1'b0, 1'b0, 32'd1,       NATIVE,      8'd11}, // R11
      '{8'h24, 16'd2,   32'd500,     32'd2,   32'd2,   1'b0, 1'b0, 32'd502,     NATIVE,      8'd2},  // R2
      '{8'hC4, 16'd40,  32'd0,       32'd40,  32'd3,   1'b0, 1'b0, 32'd40,      NATIVE,      8'd6},  // R6 default 16
      '{8'hC6, 16'd8,   32'd0,       32'd0,   32'd1,   1'b0, 1'b0, 32'd0,       NATIVE,      8'd7},  // R7
      '{8'hC5, 16'd20,  32'd64,      32'd20,  32'd3,   1'b0, 1'b0, 32'd84,      NATIVE,      8'd6},  // R6
      '{8'hC6, 16'd6,   32'd0,       32'd0,   32'd1,   1'b0, 1'b1, 32'd0,       NATIVE,      8'd7},  // R7 reject
      '{8'h39, 16'd17,  32'd0,       32'd17,  32'd3,   1'b0, 1'b0, 32'd17,      NATIVE,      8'd7},  // R7 size kept
      '{8'h00, 16'd1,   32'd5,       32'd0,   32'd1,   1'b0, 1'b1, 32'd5,       NATIVE,      8'd9},  // R9
      '{8'hB0, 16'd1,   32'd6,       32'd0,   32'd1,   1'b0, 1'b1, 32'd6,       NATIVE,      8'd9},  // R9
      '{8'h40, 16'd5,   32'd10,      32'd0,   32'd1,   1'b0, 1'b0, 32'd15,      NATIVE,      8'd8},  // R8
      '{8'h20, 16'd2,   32'hFFFFF,   32'd0,   32'd1,   1'b1, 1'b0, 32'hFFFFF,   NATIVE,      8'd3},  // R3
      '{8'h20, 16'd0,   32'd0,       32'd256, 32'd256, 1'b0, 1'b0, 32'd256,     NATIVE,      8'd1},  // R1 zero
      '{8'hF9, 16'd0,   32'h1000,    32'd0,   32'd1,   1'b0, 1'b0, 32'h1000,    32'h1000,    8'd4},  // R4
      '{8'h20, 16'd1,   32'h1000,    32'd1,   32'd1,   1'b0, 1'b0, 32'h1001,    32'h1000,    8'd3},  // R3 edge
      '{8'h20, 16'd2,   32'h1000,    32'd0,   32'd1,   1'b1, 1'b0, 32'h1000,    32'h1000,    8'd3},  // R3
      '{8'hF8, 16'd0,   32'd0,       32'd0,   32'd1,   1'b0, 1'b0, NATIVE,      32'h1000,    8'd5},  // R5
      '{8'h37, 16'd0,   32'h200000,  32'd0,   32'd1,   1'b0, 1'b1, 32'h200000,  32'h1000,    8'd4},  // R4 reject
      '{8'h37, 16'd0,   NATIVE,      32'd0,   32'd1,   1'b0, 1'b0, NATIVE,      NATIVE,      8'd4},  // R4
      '{8'hC6, 16'd0,   32'd0,       32'd0,   32'd1,   1'b0, 1'b1, 32'd0,       NATIVE,      8'd7},  // R7 zero
      '{8'hC6, 16'd128, 32'd0,       32'd0,   32'd1,   1'b0, 1'b0, 32'd0,       NATIVE,      8'd7},  // R7 max
      '{8'hC4, 16'd130, 32'd0,       32'd130, 32'd2,   1'b0, 1'b0, 32'd130,     NATIVE,      8'd6}   // R6 partial
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [7:0]  cmd_op = '0;
   logic [15:0] cmd_count = '0;
   logic [31:0] cmd_lba = '0;
   logic        sector_done = 1'b0;
   logic        bsy, drq, intrq, err_idnf, err_abort;
   logic [31:0] cur_lba, max_lba;

   int n_chk = 0;
   int n_fail = 0;
   int irq_n = 0;
   int sect_n = 0;
   bit drq_seen = 1'b0;

   always #(CLK_P / 2) clk = ~clk;

   ata_xfer_seq dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_count(cmd_count), .cmd_lba(cmd_lba), .sector_done(sector_done),
      .bsy(bsy), .drq(drq), .intrq(intrq), .err_idnf(err_idnf),
      .err_abort(err_abort), .cur_lba(cur_lba), .max_lba(max_lba)
   );

   always @(posedge clk) begin
      #1;
      if (intrq) irq_n++;
      if (drq) drq_seen = 1'b1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [7:0] op, input logic [15:0] cnt, input logic [31:0] lba);
      @(negedge clk);
      cmd_op = op; cmd_count = cnt; cmd_lba = lba; cmd_valid = 1'b1;
      irq_n = 0; drq_seen = 1'b0; sect_n = 0;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic finish_cmd();
      int w = 0;
      while (bsy && w < 100000) begin
         @(negedge clk);
         w++;
      end
      while (drq && sect_n < 70000) begin
         sector_done = 1'b1;
         @(negedge clk);
         sector_done = 1'b0;
         sect_n++;
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 190000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 / R4 reset state
      chk(!bsy && !drq && !intrq, "R10", "reset bsy/drq/intrq", {bsy, drq, intrq}, 0);
      chk(!err_idnf && !err_abort, "R10", "reset flags", {err_idnf, err_abort}, 0);
      chk(max_lba == NATIVE, "R4", "reset max_lba", max_lba, NATIVE);

      for (int i = 0; i < NV; i++) begin
         string rq;
         rq = $sformatf("R%0d vec%0d", VEC[i].req, i);
         issue(VEC[i].op, VEC[i].cnt, VEC[i].lba);
         finish_cmd();
         chk(sect_n == int'(VEC[i].sect), rq, "sectors", sect_n, VEC[i].sect);
         chk(irq_n == int'(VEC[i].irqs), rq, "interrupts", irq_n, VEC[i].irqs);
         chk(err_idnf == VEC[i].idnf, rq, "err_idnf", err_idnf, VEC[i].idnf);
         chk(err_abort == VEC[i].abrt, rq, "err_abort", err_abort, VEC[i].abrt);
         chk(cur_lba == VEC[i].cur, rq, "cur_lba", cur_lba, VEC[i].cur);
         chk(max_lba == VEC[i].mx, rq, "max_lba", max_lba, VEC[i].mx);
         chk(drq_seen == (VEC[i].sect != 0), rq, "drq seen", drq_seen, VEC[i].sect != 0);
         chk(!bsy && !drq, rq, "idle after", {bsy, drq}, 0);
      end

      // R10 cycle timing of a read, plus flag hold and clear
      issue(8'h00, 16'd0, 32'd0);
      repeat (5) @(negedge clk);
      chk(err_abort, "R10", "abort held", err_abort, 1);
      issue(8'h20, 16'd1, 32'd7);
      chk(bsy && !drq, "R10", "bsy after strobe", {bsy, drq}, 2);
      chk(!err_abort, "R10", "flag cleared by strobe", err_abort, 0);
      @(negedge clk);
      chk(!bsy && drq, "R10", "drq one clock later", {bsy, drq}, 1);
      sector_done = 1'b1;
      @(negedge clk);
      sector_done = 1'b0;
      chk(cur_lba == 32'd8 && !drq, "R10", "lba step on sector", cur_lba, 8);
      chk(irq_n == 1, "R11", "one interrupt per sector", irq_n, 1);

      // R8 verify takes one clock per sector
      issue(8'h40, 16'd4, 32'd20);
      repeat (4) @(negedge clk);
      chk(bsy && cur_lba == 32'd23, "R8", "verify progress", cur_lba, 23);
      @(negedge clk);
      chk(!bsy && cur_lba == 32'd24 && irq_n == 1, "R8", "verify end", cur_lba, 24);

      // R2 extended verify with zero count spans 65536 sectors
      issue(8'h42, 16'd0, 32'd0);
      finish_cmd();
      chk(cur_lba == 32'd65536, "R2", "ext zero count", cur_lba, 65536);
      chk(irq_n == 1 && !drq_seen, "R8", "ext verify no drq", {irq_n, drq_seen}, 2);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule